// File: doc/BRIEF.md
# Maskable Interrupt Aggregator

This block merges seventeen sticky status flags from a network controller core into a single interrupt pin. An event pulse that lasts one cycle sets a flag, and a flag stays set until software writes a one to its bit. Each flag has its own gating bit. Whether that bit blocks the flag or lets it through depends on the flag: some flags use a mask, where a 1 suppresses the flag, and the others use an enable, where a 1 allows it. A global enable input gates the merged request before it reaches the pin.

The pin is modelled as an output-enable and data pair. In level mode, the pin behaves as an open-drain, active-low request: the enable is asserted while the request is pending, and the data bit stays 0. In edge mode, the pin is always driven and gives an active-high pulse one cycle wide each time the gated request rises. While reset is held, the pin carries a test-chain input instead of the interrupt.

Top module: `irq_aggregator`

## Requirements
- R1: There are seventeen flags, indexed 0..16 in this order: excessive deferral, initialization done, memory error, missed frame, missed-frame counter overflow, wake packet, receive collision counter overflow, receive, system error, transmit, transmit start, user, management command complete, PHY detect transition, auto-poll, management read error, software timer. `flag_q[i]` shows the stored flag i.
- R2: A 1 on `evt_pulse[i]` at a clock edge sets `flag_q[i]` after that edge. If a set and a clear of the same bit arrive in the same cycle, the flag ends up set.
- R3: When `clr_wr` is 1, each `clr_data` bit that is 1 clears its flag after the edge. A `clr_data` bit that is 0 leaves its flag unchanged. When `clr_wr` is 0, no flag is cleared.
- R4: When `gate_wr` is 1, `gate_data` is loaded into `gate_q`. Indices 0, 5, 12, 13, 14, 15 and 16 are enable-type: a gate bit of 1 lets the flag through. All other indices are mask-type: a gate bit of 1 suppresses the flag.
- R5: The request is pending when `glb_en` is 1 and at least one set flag passes its gating bit.
- R6: In level mode (`edge_mode` = 0), `pin_oe` equals the pending request and `pin_o` is always 0.
- R7: In edge mode (`edge_mode` = 1), `pin_oe` is 1 and `pin_o` is 1 for exactly one cycle after each 0-to-1 change of the pending request. A further flag that arrives while the request is already pending gives no new pulse.
- R8: While `rst_n` is 0, `pin_oe` is 1 and `pin_o` follows `test_in`.
- R9: The synchronous reset clears all flags, all gating bits and the request history.
- R10: While `glb_en` is 0, no request reaches the pin in either mode, even when flags are pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| evt_pulse | input | 17 | One-cycle set events, one per flag |
| clr_wr | input | 1 | Strobe for a write-one-to-clear access |
| clr_data | input | 17 | Write data for the clear access |
| gate_wr | input | 1 | Strobe to load the gating bits |
| gate_data | input | 17 | New gating bits |
| glb_en | input | 1 | Global interrupt enable |
| edge_mode | input | 1 | 0: active-low level request, 1: active-high edge pulse |
| test_in | input | 1 | Test-chain value driven onto the pin during reset |
| flag_q | output | 17 | Stored flags |
| gate_q | output | 17 | Stored gating bits |
| pin_oe | output | 1 | Pin output enable (in level mode, drives the pin low) |
| pin_o | output | 1 | Pin data value |

## Verification
The flags and gating bits are readable at `flag_q` and `gate_q`, so a wrong set, clear or load shows at those ports on the cycle right after the edge that caused it. A polarity applied to the wrong index, or a missing global gate, shows on `pin_oe` in level mode in the same cycle the flag or gate bit changes. A stale or wrong history register shows one edge later in edge mode, as a missing pulse, a doubled pulse or a pulse with no new rise.

// File: rtl/irqa_pkg.sv
// Package: shared constants and the output-mode type for the interrupt aggregator.
// Assumes: the flag ordering below is fixed; other blocks decode it.
package irqa_pkg;
    localparam int unsigned IRQA_NUM_FLAGS = 17;

    // Gating polarity per index: 1 = enable-type, 0 = mask-type.
    localparam logic [IRQA_NUM_FLAGS-1:0] IRQA_ENABLE_TYPE = 17'b1_1111_0000_0010_0001;

    typedef enum logic {
        PIN_LEVEL = 1'b0,
        PIN_EDGE  = 1'b1
    } pin_mode_e;
endpackage

// File: rtl/irqa_flag_bank.sv
// Module: irqa_flag_bank
// Holds the sticky status flags. An event sets a flag, and a write-one-to-clear
// access clears it. If both hit the same bit in one cycle, the set wins.
// Assumes: a synchronous active-low reset; event pulses are already in this clock domain.
module irqa_flag_bank #(
    parameter int unsigned NUM_FLAGS = 17
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_FLAGS-1:0] set_evt,
    input  logic                 clr_en,
    input  logic [NUM_FLAGS-1:0] clr_bits,
    output logic [NUM_FLAGS-1:0] flags
);
    logic [NUM_FLAGS-1:0] clr_mask;

    // Clear mask: only active during a clear access.
    always_comb clr_mask = clr_en ? clr_bits : '0;

    for (genvar i = 0; i < NUM_FLAGS; i++) begin : g_flag
        // Per-flag storage: the set event has priority over the clear.
        always_ff @(posedge clk) begin
            if (!rst_n)
                flags[i] <= 1'b0;
            else if (set_evt[i])
                flags[i] <= 1'b1;
            else if (clr_mask[i])
                flags[i] <= 1'b0;
        end
    end
endmodule

// File: rtl/irqa_gate.sv
// Module: irqa_gate
// Stores the gating bits and applies the per-index polarity. Each bit is either
// a mask (1 blocks) or an enable (1 passes). Produces the gated request.
// Assumes: ENABLE_TYPE is fixed at elaboration time.
module irqa_gate #(
    parameter int unsigned          NUM_FLAGS   = 17,
    parameter logic [NUM_FLAGS-1:0] ENABLE_TYPE = '0
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 load,
    input  logic [NUM_FLAGS-1:0] load_data,
    input  logic [NUM_FLAGS-1:0] flags,
    input  logic                 glb_en,
    output logic [NUM_FLAGS-1:0] gate_bits,
    output logic                 req_any
);
    logic [NUM_FLAGS-1:0] pass;

    // Gating register: cleared by reset, loaded as a whole word.
    always_ff @(posedge clk) begin
        if (!rst_n)
            gate_bits <= '0;
        else if (load)
            gate_bits <= load_data;
    end

    for (genvar i = 0; i < NUM_FLAGS; i++) begin : g_pol
        if (ENABLE_TYPE[i]) begin : g_en
            // Enable-type: the flag passes when the gate bit is 1.
            always_comb pass[i] = flags[i] & gate_bits[i];
        end else begin : g_mask
            // Mask-type: the flag passes when the gate bit is 0.
            always_comb pass[i] = flags[i] & ~gate_bits[i];
        end
    end

    // Merged request, qualified by the global enable.
    always_comb req_any = glb_en & (|pass);
endmodule

// File: rtl/irqa_pin_mux.sv
// Module: irqa_pin_mux
// Turns the merged request into pin controls. Level mode uses an open-drain
// low drive. Edge mode gives a one-cycle high pulse on each rise. While reset
// is held, the pin carries the test-chain input.
// Assumes: the rise history is tracked in both modes, so a mode change alone
// creates no pulse.
module irqa_pin_mux
    import irqa_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      req_any,
    input  pin_mode_e mode,
    input  logic      test_in,
    output logic      pin_oe,
    output logic      pin_o
);
    logic req_d;
    logic rise;

    // Request history for rise detection.
    always_ff @(posedge clk) begin
        if (!rst_n)
            req_d <= 1'b0;
        else
            req_d <= req_any;
    end

    // A rise is a pending request with no request in the previous cycle.
    always_comb rise = req_any & ~req_d;

    // Pin selection: reset override first, then the chosen mode.
    always_comb begin
        if (!rst_n) begin
            pin_oe = 1'b1;
            pin_o  = test_in;
        end else if (mode == PIN_EDGE) begin
            pin_oe = 1'b1;
            pin_o  = rise;
        end else begin
            pin_oe = req_any;
            pin_o  = 1'b0;
        end
    end
endmodule

// File: rtl/irq_aggregator.sv
// Module: irq_aggregator (top)
// Merges the sticky status flags into one interrupt pin. Each flag has its own
// gating bit, with mask or enable polarity. The pin has a level mode and an
// edge mode, and a test override while reset is held.
// Assumes: register accesses arrive as single-cycle strobes from the register file.
module irq_aggregator
    import irqa_pkg::*;
#(
    parameter int unsigned          NUM_FLAGS   = IRQA_NUM_FLAGS,
    parameter logic [NUM_FLAGS-1:0] ENABLE_TYPE = IRQA_ENABLE_TYPE
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_FLAGS-1:0] evt_pulse,
    input  logic                 clr_wr,
    input  logic [NUM_FLAGS-1:0] clr_data,
    input  logic                 gate_wr,
    input  logic [NUM_FLAGS-1:0] gate_data,
    input  logic                 glb_en,
    input  logic                 edge_mode,
    input  logic                 test_in,
    output logic [NUM_FLAGS-1:0] flag_q,
    output logic [NUM_FLAGS-1:0] gate_q,
    output logic                 pin_oe,
    output logic                 pin_o
);
    logic      req_any;
    pin_mode_e mode;

    // Mode decode from the configuration bit.
    always_comb mode = edge_mode ? PIN_EDGE : PIN_LEVEL;

    irqa_flag_bank #(.NUM_FLAGS(NUM_FLAGS)) flags_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .set_evt  (evt_pulse),
        .clr_en   (clr_wr),
        .clr_bits (clr_data),
        .flags    (flag_q)
    );

    irqa_gate #(.NUM_FLAGS(NUM_FLAGS), .ENABLE_TYPE(ENABLE_TYPE)) gate_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (gate_wr),
        .load_data (gate_data),
        .flags     (flag_q),
        .glb_en    (glb_en),
        .gate_bits (gate_q),
        .req_any   (req_any)
    );

    irqa_pin_mux pin_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .req_any (req_any),
        .mode    (mode),
        .test_in (test_in),
        .pin_oe  (pin_oe),
        .pin_o   (pin_o)
    );
endmodule

// File: rtl/irqa_checker.sv
// Module: irqa_checker
// Protocol assertions for irq_aggregator, attached with a bind statement.
module irqa_checker #(
    parameter int unsigned NUM_FLAGS = 17
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic [NUM_FLAGS-1:0] evt_pulse,
    input logic                 clr_wr,
    input logic [NUM_FLAGS-1:0] clr_data,
    input logic                 glb_en,
    input logic                 edge_mode,
    input logic                 test_in,
    input logic [NUM_FLAGS-1:0] flag_q,
    input logic                 pin_oe,
    input logic                 pin_o
);
    // R2: every event bit is set after the edge, even if it is cleared in the same cycle.
    a_r2_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (|evt_pulse) |=> ((flag_q & $past(evt_pulse)) == $past(evt_pulse)));

    // R3: without a clear access, a flag never drops.
    a_r3_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        !clr_wr |=> ((flag_q & $past(flag_q)) == $past(flag_q)));

    // R3: a clear with no event clears the addressed bits.
    a_r3_w1c: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_wr && evt_pulse == '0) |=> ((flag_q & $past(clr_data)) == '0));

    // R6: in level mode the pin is never driven high.
    a_r6_open_drain: assert property (@(posedge clk) disable iff (!rst_n)
        !edge_mode |-> !pin_o);

    // R7: an edge-mode pulse lasts one cycle.
    a_r7_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        (edge_mode && pin_o) |=> !pin_o);

    // R8: during reset the pin carries the test input.
    a_r8_test_path: assert property (@(posedge clk)
        !rst_n |-> (pin_oe && pin_o == test_in));

    // R10: with the global enable low, no request reaches the pin.
    a_r10_global_off: assert property (@(posedge clk) disable iff (!rst_n)
        !glb_en |-> (!pin_o && (edge_mode || !pin_oe)));
endmodule

bind irq_aggregator irqa_checker #(.NUM_FLAGS(NUM_FLAGS)) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .evt_pulse (evt_pulse),
    .clr_wr    (clr_wr),
    .clr_data  (clr_data),
    .glb_en    (glb_en),
    .edge_mode (edge_mode),
    .test_in   (test_in),
    .flag_q    (flag_q),
    .pin_oe    (pin_oe),
    .pin_o     (pin_o)
);

// File: tb/irq_aggregator_tb_top.sv
// Directed bench for irq_aggregator: one task per scenario.
module irq_aggregator_tb_top;
    localparam int NF = 17;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [NF-1:0] evt_pulse = '0;
    logic          clr_wr = 1'b0;
    logic [NF-1:0] clr_data = '0;
    logic          gate_wr = 1'b0;
    logic [NF-1:0] gate_data = '0;
    logic          glb_en = 1'b0;
    logic          edge_mode = 1'b0;
    logic          test_in = 1'b0;
    logic [NF-1:0] flag_q;
    logic [NF-1:0] gate_q;
    logic          pin_oe;
    logic          pin_o;

    int n_checks = 0;
    int n_errors = 0;

    always #10 clk = ~clk;   // 50 MHz

    irq_aggregator dut_i (
        .clk(clk), .rst_n(rst_n), .evt_pulse(evt_pulse), .clr_wr(clr_wr),
        .clr_data(clr_data), .gate_wr(gate_wr), .gate_data(gate_data),
        .glb_en(glb_en), .edge_mode(edge_mode), .test_in(test_in),
        .flag_q(flag_q), .gate_q(gate_q), .pin_oe(pin_oe), .pin_o(pin_o)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Advance one edge; inputs change and outputs are sampled at the falling edge.
    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic pulse_evt(input logic [NF-1:0] bits);
        evt_pulse = bits; step(); evt_pulse = '0;
    endtask

    task automatic write_clr(input logic [NF-1:0] bits);
        clr_wr = 1'b1; clr_data = bits; step(); clr_wr = 1'b0; clr_data = '0;
    endtask

    task automatic write_gate(input logic [NF-1:0] bits);
        gate_wr = 1'b1; gate_data = bits; step(); gate_wr = 1'b0;
    endtask

    task automatic t_reset();
        rst_n = 1'b0; test_in = 1'b1;
        step();
        check("R8 oe in reset", 32'(pin_oe), 32'd1);
        check("R8 test high", 32'(pin_o), 32'd1);
        test_in = 1'b0; #1;
        check("R8 test low", 32'(pin_o), 32'd0);
        step();
        rst_n = 1'b1; step();
        check("R9 flags clear", 32'(flag_q), 32'd0);
        check("R9 gates clear", 32'(gate_q), 32'd0);
        check("R9 pin idle", 32'(pin_oe), 32'd0);
    endtask

    task automatic t_set_clear();
        pulse_evt(17'h00008);
        check("R2 set bit3", 32'(flag_q), 32'h8);
        write_clr(17'h00010);
        check("R3 zero bit keeps", 32'(flag_q), 32'h8);
        clr_data = 17'h00008; step(); clr_data = '0;
        check("R3 no strobe no clear", 32'(flag_q), 32'h8);
        write_clr(17'h00008);
        check("R3 w1c bit3", 32'(flag_q), 32'h0);
        evt_pulse = 17'h00080; clr_wr = 1'b1; clr_data = 17'h00080;
        step();
        evt_pulse = '0; clr_wr = 1'b0; clr_data = '0;
        check("R2 set beats clear", 32'(flag_q), 32'h80);
        write_clr('1);
        pulse_evt('1);
        check("R1 all seventeen", 32'(flag_q), 32'h1FFFF);
        write_clr('1);
        check("R1 all cleared", 32'(flag_q), 32'h0);
    endtask

    task automatic t_gating();
        glb_en = 1'b1; edge_mode = 1'b0;
        pulse_evt(17'h00002);                  // index 1, mask-type
        check("R5 mask-type passes at 0", 32'(pin_oe), 32'd1);
        check("R6 level data low", 32'(pin_o), 32'd0);
        write_gate(17'h00002);
        check("R4 gate readback", 32'(gate_q), 32'h2);
        check("R4 mask blocks", 32'(pin_oe), 32'd0);
        write_clr(17'h00002);
        write_gate('0);
        pulse_evt(17'h01000);                  // index 12, enable-type
        check("R4 enable-type blocked at 0", 32'(pin_oe), 32'd0);
        write_gate(17'h01000);
        check("R6 enable passes", 32'(pin_oe), 32'd1);
        glb_en = 1'b0; #1;
        check("R10 global off level", 32'(pin_oe), 32'd0);
        glb_en = 1'b1;
        write_clr('1);
        check("R6 request drops", 32'(pin_oe), 32'd0);
        write_gate('0);
    endtask

    task automatic t_edge();
        edge_mode = 1'b1; glb_en = 1'b1;
        step();
        check("R7 oe always", 32'(pin_oe), 32'd1);
        pulse_evt(17'h00004);
        check("R7 pulse on rise", 32'(pin_o), 32'd1);
        step();
        check("R7 pulse ends", 32'(pin_o), 32'd0);
        pulse_evt(17'h00100);
        check("R7 no pulse when already pending", 32'(pin_o), 32'd0);
        write_clr('1);
        step();
        pulse_evt(17'h00004);
        check("R7 second rise pulses", 32'(pin_o), 32'd1);
        write_clr('1);
        glb_en = 1'b0;
        pulse_evt(17'h00001 << 3);
        check("R10 global off edge", 32'(pin_o), 32'd0);
        write_clr('1);
    endtask

    initial begin
        #(20 * 200000);
        n_errors++;
        $display("FAIL watchdog: actual=timeout expected=done");
        $display("  Result: errors=%0d of %0d checks", n_errors, n_checks + 1);
        $finish;
    end

    initial begin
        @(negedge clk);
        t_reset();
        t_set_clear();
        t_gating();
        t_edge();
        $display("  Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end
endmodule